// File: doc/BRIEF.md
# Strobe-Driven Page Access Sequencer

This block sits in front of a row-buffered memory core and turns a set of active-low row strobe, column strobe and write-enable levels into a stream of core commands. All strobes and the shared address bus are sampled on the system clock. A falling row strobe opens a row. A rising row strobe closes it. Between those two points any number of column reads or writes are sent to the open row, and the row is never re-activated.

Column accesses are started in one of two ways, chosen by a level on `static_sel`. In pulsed mode, each falling edge of the column strobe starts one access. In static mode, the column strobe stays low for the whole page. The first access starts when the strobe falls, and each later change of the sampled address starts another access with no strobe edge. Each access is a read or a write, set by the write-enable level sampled in the same clock as the trigger.

Top module: `strobe_page_ctrl`

## Requirements
- R1: During and after a synchronous reset (`rst` high), `cmd` is idle, and `row_out` and `col_out` are zero. The command codes are: idle = 0, activate = 1, read = 2, write = 3, precharge = 4.
- R2: When the sampled `ras_n` goes from 1 to 0, one activate command is issued, and `row_out` takes the address sampled in that same clock.
- R3: With `static_sel` = 0 and a row open, each sampled 1-to-0 transition of `cas_n` issues exactly one column command, and `col_out` takes the address sampled in that clock.
- R4: With `static_sel` = 1 and a row open, `cas_n` held low issues one column command on its falling sample and one on each clock whose sampled address differs from the previous sample. A steady address issues nothing.
- R5: When the sampled `ras_n` goes from 0 to 1 while a row is open, one precharge command is issued. After that, no column command is issued until the next activate.
- R6: A column command is a write when `we_n` is sampled 0 in its trigger clock, and a read when `we_n` is sampled 1.
- R7: While `ras_n` is high, activity on `cas_n` and on the address issues no command. A `cas_n` fall sampled in the same clock as the `ras_n` fall gives only the activate.
- R8: Several column commands can follow one activate with no further activate in between, and `row_out` holds its value through all of them.
- R9: Every command appears on `cmd` for exactly one clock, on the second rising edge after the edge that samples the strobe or address change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Shared row/column address |
| static_sel | input | 1 | 0 = pulsed column strobe, 1 = static column |
| cmd | output | 3 | Core command code (R1 encoding) |
| row_out | output | ADDR_W | Row address of the last activate |
| col_out | output | ADDR_W | Column address of the last read or write |

## Verification
The block keeps three kinds of internal state: whether a row is open, the previous sample of each strobe, and the previous address. If any of these is wrong, the fault appears on `cmd` within two clocks of the next strobe or address change. It shows up as a lost or duplicated activate, a column command after a precharge, or a static-mode access that repeats on a steady address. A wrong capture register shows up at once as a stale `row_out` or `col_out` in the clock where the command is issued. The bench therefore compares all three outputs against its reference model on every clock. This catches each such fault in the first cycle it becomes visible.

// File: rtl/strobe_page_pkg.sv
package strobe_page_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4
  } core_cmd_e;
endpackage

// File: rtl/strobe_sampler.sv
module strobe_sampler #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              static_sel,
  output logic              ras_fell,
  output logic              ras_rose,
  output logic              ras_low,
  output logic              cas_fell,
  output logic              cas_low,
  output logic              we_low,
  output logic              addr_moved,
  output logic              mode_static,
  output logic [ADDR_W-1:0] addr_now
);
  logic              ras_q, ras_qq, cas_q, cas_qq, we_q, mode_q;
  logic [ADDR_W-1:0] addr_q, addr_qq;

  // one sample stage plus one history stage for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      ras_q   <= 1'b1;
      ras_qq  <= 1'b1;
      cas_q   <= 1'b1;
      cas_qq  <= 1'b1;
      we_q    <= 1'b1;
      mode_q  <= 1'b0;
      addr_q  <= '0;
      addr_qq <= '0;
    end else begin
      ras_q   <= ras_n;
      ras_qq  <= ras_q;
      cas_q   <= cas_n;
      cas_qq  <= cas_q;
      we_q    <= we_n;
      mode_q  <= static_sel;
      addr_q  <= addr;
      addr_qq <= addr_q;
    end
  end

  assign ras_fell    = ras_qq & ~ras_q;
  assign ras_rose    = ~ras_qq & ras_q;
  assign ras_low     = ~ras_q;
  assign cas_fell    = cas_qq & ~cas_q;
  assign cas_low     = ~cas_q;
  assign we_low      = ~we_q;
  assign addr_moved  = (addr_q != addr_qq);
  assign mode_static = mode_q;
  assign addr_now    = addr_q;
endmodule

// File: rtl/page_decider.sv
module page_decider
  import strobe_page_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ras_fell,
  input  logic      ras_rose,
  input  logic      ras_low,
  input  logic      cas_fell,
  input  logic      cas_low,
  input  logic      we_low,
  input  logic      addr_moved,
  input  logic      mode_static,
  output core_cmd_e next_cmd
);
  logic row_open;
  logic col_trig;

  // column trigger depends on the page mode
  always_comb begin
    if (mode_static) col_trig = cas_low & (cas_fell | addr_moved);
    else             col_trig = cas_fell;
  end

  always_comb begin
    next_cmd = CMD_IDLE;
    if (ras_fell)                          next_cmd = CMD_ACT;
    else if (ras_rose && row_open)         next_cmd = CMD_PRE;
    else if (row_open && ras_low && col_trig)
      next_cmd = we_low ? CMD_WR : CMD_RD;
  end

  always_ff @(posedge clk) begin
    if (rst)           row_open <= 1'b0;
    else if (ras_fell) row_open <= 1'b1;
    else if (ras_rose) row_open <= 1'b0;
  end
endmodule

// File: rtl/cmd_issue_reg.sv
module cmd_issue_reg
  import strobe_page_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  core_cmd_e         next_cmd,
  input  logic [ADDR_W-1:0] addr_now,
  output logic [2:0]        cmd,
  output logic [ADDR_W-1:0] row_out,
  output logic [ADDR_W-1:0] col_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd     <= CMD_IDLE;
      row_out <= '0;
      col_out <= '0;
    end else begin
      cmd <= next_cmd;
      if (next_cmd == CMD_ACT) row_out <= addr_now;
      if (next_cmd == CMD_RD || next_cmd == CMD_WR) col_out <= addr_now;
    end
  end
endmodule

// File: rtl/strobe_page_ctrl.sv
module strobe_page_ctrl
  import strobe_page_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              static_sel,
  output logic [2:0]        cmd,
  output logic [ADDR_W-1:0] row_out,
  output logic [ADDR_W-1:0] col_out
);
  logic              ras_fell, ras_rose, ras_low, cas_fell, cas_low;
  logic              we_low, addr_moved, mode_static;
  logic [ADDR_W-1:0] addr_now;
  core_cmd_e         next_cmd;

  strobe_sampler #(.ADDR_W(ADDR_W)) u_sample (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .static_sel(static_sel),
    .ras_fell(ras_fell), .ras_rose(ras_rose), .ras_low(ras_low),
    .cas_fell(cas_fell), .cas_low(cas_low), .we_low(we_low),
    .addr_moved(addr_moved), .mode_static(mode_static), .addr_now(addr_now)
  );

  page_decider u_decide (
    .clk(clk), .rst(rst), .ras_fell(ras_fell), .ras_rose(ras_rose),
    .ras_low(ras_low), .cas_fell(cas_fell), .cas_low(cas_low),
    .we_low(we_low), .addr_moved(addr_moved), .mode_static(mode_static),
    .next_cmd(next_cmd)
  );

  cmd_issue_reg #(.ADDR_W(ADDR_W)) u_issue (
    .clk(clk), .rst(rst), .next_cmd(next_cmd), .addr_now(addr_now),
    .cmd(cmd), .row_out(row_out), .col_out(col_out)
  );
endmodule

// File: rtl/strobe_page_ctrl_chk.sv
module strobe_page_ctrl_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic              static_sel,
  input logic [2:0]        cmd,
  input logic [ADDR_W-1:0] row_out,
  input logic [ADDR_W-1:0] col_out
);
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> cmd == 3'd0);

  a_r2_act_row: assert property (@(posedge clk) disable iff (rst)
    cmd == 3'd1 |-> ($past(ras_n, 2) == 1'b0 && row_out == $past(addr, 2)));

  a_r3_col_addr: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd2 || cmd == 3'd3) |-> ($past(ras_n, 2) == 1'b0 && col_out == $past(addr, 2)));

  a_r3_pulsed_needs_cas: assert property (@(posedge clk) disable iff (rst)
    ((cmd == 3'd2 || cmd == 3'd3) && $past(static_sel, 2) == 1'b0) |-> $past(cas_n, 2) == 1'b0);

  a_r5_pre_on_rise: assert property (@(posedge clk) disable iff (rst)
    cmd == 3'd4 |-> $past(ras_n, 2) == 1'b1);

  a_r6_write_we: assert property (@(posedge clk) disable iff (rst)
    cmd == 3'd3 |-> $past(we_n, 2) == 1'b0);

  a_r6_read_we: assert property (@(posedge clk) disable iff (rst)
    cmd == 3'd2 |-> $past(we_n, 2) == 1'b1);

  a_r8_row_held: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd2 || cmd == 3'd3) |-> $stable(row_out));

  a_r9_legal_code: assert property (@(posedge clk) disable iff (rst)
    cmd <= 3'd4);
endmodule

bind strobe_page_ctrl strobe_page_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .addr(addr), .static_sel(static_sel), .cmd(cmd),
  .row_out(row_out), .col_out(col_out)
);

// File: tb/strobe_page_ctrl_test.sv
module strobe_page_ctrl_test;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, static_sel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [2:0]    cmd;
  logic [AW-1:0] row_out, col_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  strobe_page_ctrl #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .static_sel(static_sel), .cmd(cmd),
    .row_out(row_out), .col_out(col_out)
  );

  // behavioural reference: two sample slots plus open-row flag
  int            c_ras, o_ras, c_cas, o_cas, c_we, c_mode;
  logic [AW-1:0] c_addr, o_addr;
  bit            open_row;
  int            e_cmd, e_mode;
  logic [AW-1:0] e_row, e_col;
  bit            live = 0;

  always @(posedge clk) begin : model
    int  n;
    bit  trig;
    if (rst) begin
      c_ras = 1; o_ras = 1; c_cas = 1; o_cas = 1; c_we = 1; c_mode = 0;
      c_addr = '0; o_addr = '0; open_row = 0;
      e_cmd = 0; e_row = '0; e_col = '0; e_mode = 0; live = 1;
    end else begin
      n = 0;
      if (o_ras == 1 && c_ras == 0) begin
        n = 1; open_row = 1;
      end else if (o_ras == 0 && c_ras == 1) begin
        if (open_row) n = 4;
        open_row = 0;
      end else if (open_row && c_ras == 0) begin
        if (c_mode == 1) trig = (c_cas == 0) && (o_cas == 1 || c_addr != o_addr);
        else             trig = (o_cas == 1 && c_cas == 0);
        if (trig) n = (c_we == 0) ? 3 : 2;
      end
      if (n == 1) e_row = c_addr;
      if (n == 2 || n == 3) e_col = c_addr;
      e_cmd = n; e_mode = c_mode;
      o_ras = c_ras; o_cas = c_cas; o_addr = c_addr;
      c_ras = int'(ras_n); c_cas = int'(cas_n); c_we = int'(we_n);
      c_mode = int'(static_sel); c_addr = addr;
    end
  end

  function automatic string tag_of(int c, int m);
    case (c)
      0: tag_of = rst ? "R1" : (m == 1 ? "R4" : "R7");
      1: tag_of = "R2 R9";
      2, 3: tag_of = (m == 1) ? "R4 R6" : "R3 R6";
      default: tag_of = "R5";
    endcase
  endfunction

  always @(negedge clk) begin
    if (live && !done) begin
      total++;
      if (int'(cmd) !== e_cmd) begin
        bad++;
        $display("FAIL %s cmd actual=%0d expected=%0d t=%0t", tag_of(e_cmd, e_mode), cmd, e_cmd, $time);
      end
      total++;
      if (row_out !== e_row) begin
        bad++;
        $display("FAIL R8 row_out actual=%0h expected=%0h t=%0t", row_out, e_row, $time);
      end
      total++;
      if (col_out !== e_col) begin
        bad++;
        $display("FAIL R3 col_out actual=%0h expected=%0h t=%0t", col_out, e_col, $time);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(bit r, bit c, bit w, logic [AW-1:0] a);
    @(negedge clk);
    ras_n = r; cas_n = c; we_n = w; addr = a;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    tick(4);
    @(negedge clk); rst = 1'b0;            // R1 checked through reset cycles
    tick(3);
    // R7: column and address activity with row closed
    put(1, 0, 0, 10'h011); put(1, 1, 1, 10'h022); put(1, 0, 1, 10'h033); put(1, 1, 1, 10'h0);
    tick(3);
    // R2 R3 R6 R8: pulsed page with several columns
    static_sel = 1'b0;
    put(0, 1, 1, 10'h155); tick(2);
    put(0, 0, 1, 10'h004); put(0, 1, 1, 10'h004);
    put(0, 0, 0, 10'h008); put(0, 0, 0, 10'h009); put(0, 1, 1, 10'h009);
    put(0, 0, 1, 10'h3FF); put(0, 1, 1, 10'h3FF);
    put(1, 1, 1, 10'h0); tick(3);           // R5
    // R7: CAS falls together with RAS
    put(0, 0, 1, 10'h0AA); tick(2); put(0, 1, 1, 10'h0AA); tick(2);
    put(1, 1, 1, 10'h0); tick(3);
    // R4: static column page
    static_sel = 1'b1;
    put(0, 1, 1, 10'h2A0); tick(2);
    put(0, 0, 1, 10'h010); tick(2);
    put(0, 0, 1, 10'h011); put(0, 0, 0, 10'h012); tick(3);
    put(0, 0, 1, 10'h012); put(0, 0, 1, 10'h100);
    put(0, 1, 1, 10'h101); put(0, 1, 1, 10'h102);
    put(1, 1, 1, 10'h103); tick(3);          // R5 then no column
    put(1, 0, 1, 10'h104); put(1, 0, 1, 10'h105); tick(3);
    // mixed random activity
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 15) == 0) ras_n = ~ras_n;
      if ($urandom_range(0, 3) == 0) cas_n = ~cas_n;
      if ($urandom_range(0, 3) == 0) we_n = $urandom_range(0, 1);
      if ($urandom_range(0, 2) == 0) addr = AW'($urandom_range(0, 7));
      if ($urandom_range(0, 199) == 0) static_sel = ~static_sel;
    end
    put(1, 1, 1, 10'h0); tick(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule